// File: doc/BRIEF.md
# Oscillator Startup Timer Controller

This block is the digital control and status logic that sits beside an external crystal oscillator. A mode controller drives an enable input to switch the oscillator on. On every off-to-on change of that enable, a stabilization counter starts again from zero. It advances once per oscillator reference cycle, which arrives as a synchronous tick strobe. When the counter reaches a programmable byte times 512, the block reports the oscillator clock as available and latches an interrupt pending flag. The interrupt output follows that flag, gated by a mask bit.

A set-only bypass bit covers the case where an external clock is driven in place of a crystal. Once set, it forces the available status high at once, whatever the enable is doing, and only a reset clears it. All control sits in one 32-bit register on a simple write-strobe bus, and that register is read back combinationally.

The sequencer is a four-state machine. OFF holds the counter at zero. COUNT advances the counter on each tick. READY saturates the counter and reports availability. BYPASS is terminal until reset. The transitions are:
- OFF to COUNT when the enable is sampled high.
- COUNT to READY when the count has reached the threshold, which also sets the pending flag.
- COUNT to OFF and READY to OFF when the enable is sampled low.
- Any state to BYPASS once the bypass bit is set.

Top module: `osc_startup_ctrl`

## Requirements
- R1: After reset the control register reads 0x0080_0000, and both the available output and the interrupt output are 0.
- R2: With the tick held high and bypass clear, the available output is first seen high at the (EOC*512+2)-th rising edge. The count starts with the edge that first samples the enable high. EOC is register bits [23:16].
- R3: The counter advances only on cycles with the tick high. If the enable is already sampled high and the tick is then raised, the available output rises at edge EOC*512+1 counted from the tick.
- R4: Completing the count sets the pending flag, register bit 0. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged. A set and a clear in the same cycle leave it set.
- R5: The interrupt output equals the pending flag ANDed with the mask bit, register bit 8.
- R6: Writing 1 to bit 31 sets the bypass bit. Writing 0 never clears it; only reset does.
- R7: While bypass is set, the available output is 1 from the cycle after the write, whether the enable is high or low. Bypass does not set the pending flag.
- R8: Without bypass, dropping the enable clears the available output in the same cycle. A later rising enable restarts the full count from zero.
- R9: The counter saturates at the threshold, so the available output stays high for as long as the enable stays high.
- R10: Bits [23:16], bit 8 and bit 31 are writable. All bits outside bits 31, [23:16], 8 and 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| osc_en_i | input | 1 | Oscillator power-on request from the mode controller |
| osc_tick_i | input | 1 | One pulse per oscillator reference cycle, synchronous to clk |
| reg_wr_i | input | 1 | Write strobe for the control register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Control register read value |
| clk_avail_o | output | 1 | Oscillator clock available status |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench sweeps the end-of-count byte over 0 to 3 and measures the exact edge at which availability first appears. An off-by-one in the compare or in the restart would move that edge by one cycle. It drops the enable mid-count and after completion, then re-enables. A counter that failed to restart would finish early, and availability that lagged the enable would stay high for a cycle. Bypass is exercised with the enable both low and high, and with attempted clears. A bit that could be written back to 0, or a bypass that raised the pending flag, shows at the register and the outputs. The bench also collides a pending clear with count completion and holds the enable for over a thousand cycles past completion. A clear that wins the collision, or a counter that wraps, shows up in those two tests.

// File: rtl/osc_startup_pkg.sv
package osc_startup_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_COUNT  = 2'd1,
        ST_READY  = 2'd2,
        ST_BYPASS = 2'd3
    } osc_state_e;

    localparam int REG_W    = 32;
    localparam int BIT_PEND = 0;
    localparam int BIT_MASK = 8;
    localparam int EOC_LSB  = 16;
    localparam int BIT_BYP  = 31;
endpackage

// File: rtl/osc_ctl_regs.sv
module osc_ctl_regs
    import osc_startup_pkg::*;
#(
    parameter int             EOC_W   = 8,
    parameter logic [EOC_W-1:0] EOC_RST = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             done_i,
    output logic [REG_W-1:0] rdata_o,
    output logic [EOC_W-1:0] eoc_o,
    output logic             mask_o,
    output logic             pend_o,
    output logic             byp_o
);
    logic [EOC_W-1:0] eoc_q;
    logic             mask_q;
    logic             pend_q;
    logic             byp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoc_q  <= EOC_RST;
            mask_q <= 1'b0;
            byp_q  <= 1'b0;
        end else if (wr_i) begin
            eoc_q  <= wdata_i[EOC_LSB +: EOC_W];
            mask_q <= wdata_i[BIT_MASK];
            byp_q  <= byp_q | wdata_i[BIT_BYP];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (done_i) begin
            pend_q <= 1'b1;
        end else if (wr_i && wdata_i[BIT_PEND]) begin
            pend_q <= 1'b0;
        end
    end

    always_comb begin
        rdata_o                       = '0;
        rdata_o[EOC_LSB +: EOC_W]     = eoc_q;
        rdata_o[BIT_MASK]             = mask_q;
        rdata_o[BIT_PEND]             = pend_q;
        rdata_o[BIT_BYP]              = byp_q;
    end

    assign eoc_o  = eoc_q;
    assign mask_o = mask_q;
    assign pend_o = pend_q;
    assign byp_o  = byp_q;
endmodule

// File: rtl/osc_stab_fsm.sv
module osc_stab_fsm
    import osc_startup_pkg::*;
#(
    parameter int EOC_W       = 8,
    parameter int SCALE_SHIFT = 9,
    localparam int CNT_W      = EOC_W + SCALE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             byp_i,
    input  logic [EOC_W-1:0] eoc_i,
    output logic             done_o,
    output logic             avail_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] thr_o
);
    osc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] thr;
    logic             reached;

    assign thr     = {eoc_i, {SCALE_SHIFT{1'b0}}};
    assign reached = (cnt_q >= thr);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_o  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                cnt_d = '0;
                if (byp_i)     state_d = ST_BYPASS;
                else if (en_i) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (byp_i) begin
                    state_d = ST_BYPASS;
                end else if (!en_i) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else if (reached) begin
                    state_d = ST_READY;
                    done_o  = 1'b1;
                end else if (tick_i) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_READY: begin
                if (byp_i) begin
                    state_d = ST_BYPASS;
                end else if (!en_i) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end
            end
            ST_BYPASS: begin
                state_d = ST_BYPASS;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        avail_o = byp_i | ((state_q == ST_READY) & en_i);
        cnt_o   = cnt_q;
        thr_o   = thr;
    end
endmodule

// File: rtl/osc_startup_ctrl.sv
module osc_startup_ctrl
    import osc_startup_pkg::*;
#(
    parameter int             EOC_W       = 8,
    parameter int             SCALE_SHIFT = 9,
    parameter logic [EOC_W-1:0] EOC_RST   = 8'h80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_en_i,
    input  logic        osc_tick_i,
    input  logic        reg_wr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic        clk_avail_o,
    output logic        irq_o
);
    localparam int CNT_W = EOC_W + SCALE_SHIFT;

    logic [EOC_W-1:0] eoc_w;
    logic             mask_w;
    logic             pend_w;
    logic             byp_w;
    logic             done_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] thr_w;

    osc_ctl_regs #(
        .EOC_W   (EOC_W),
        .EOC_RST (EOC_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .done_i  (done_w),
        .rdata_o (reg_rdata_o),
        .eoc_o   (eoc_w),
        .mask_o  (mask_w),
        .pend_o  (pend_w),
        .byp_o   (byp_w)
    );

    osc_stab_fsm #(
        .EOC_W       (EOC_W),
        .SCALE_SHIFT (SCALE_SHIFT)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (osc_en_i),
        .tick_i  (osc_tick_i),
        .byp_i   (byp_w),
        .eoc_i   (eoc_w),
        .done_o  (done_w),
        .avail_o (clk_avail_o),
        .cnt_o   (cnt_w),
        .thr_o   (thr_w)
    );

    assign irq_o = pend_w & mask_w;
endmodule

// File: rtl/osc_startup_checker.sv
module osc_startup_checker #(
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osc_en_i,
    input logic [31:0]      reg_rdata_o,
    input logic             clk_avail_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] cnt_w
);
    // R5: the interrupt follows pending AND mask.
    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o[0] && reg_rdata_o[8]) |-> irq_o);
    p_irq_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rdata_o[0] && reg_rdata_o[8]) |-> !irq_o);
    // R6: once set, bypass stays set until reset.
    p_byp_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[31] |=> reg_rdata_o[31]);
    // R7: bypass forces availability.
    p_byp_avail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[31] |-> clk_avail_o);
    // R8: no availability with the enable low and no bypass.
    p_off_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en_i && !reg_rdata_o[31]) |-> !clk_avail_o);
    // R4: availability rising from a count always comes with pending set.
    p_pend_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clk_avail_o) && !reg_rdata_o[31]) |-> reg_rdata_o[0]);
    // R9: the counter never passes the threshold.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_w <= {reg_rdata_o[23:16], 9'd0});
endmodule

bind osc_startup_ctrl osc_startup_checker #(.CNT_W(EOC_W + SCALE_SHIFT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_en_i    (osc_en_i),
    .reg_rdata_o (reg_rdata_o),
    .clk_avail_o (clk_avail_o),
    .irq_o       (irq_o),
    .cnt_w       (cnt_w)
);

// File: tb/osc_startup_ctrl_bench.sv
`timescale 1ns/1ps
module osc_startup_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_en_i = 1'b0;
    logic        osc_tick_i = 1'b1;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        clk_avail_o;
    logic        irq_o;

    int n_total = 0;
    int n_fail  = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    osc_startup_ctrl u_osc_startup_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_en_i    (osc_en_i),
        .osc_tick_i  (osc_tick_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .clk_avail_o (clk_avail_o),
        .irq_o       (irq_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        osc_en_i = 1'b0;
        osc_tick_i = 1'b1;
        reg_wr_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1;
        reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
        reg_wdata_i = '0;
    endtask

    // Counts falling edges from now until availability is seen.
    task automatic wait_avail(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!clk_avail_o && n < 5000);
    endtask

    initial begin
        #(200000 * 8);
        if (!done_flag) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int n;
        do_reset();
        // R1 reset state
        check("R1 rdata", reg_rdata_o, 32'h0080_0000);
        check("R1 avail", clk_avail_o, 0);
        check("R1 irq", irq_o, 0);

        // R10 writable fields and zero bits
        reg_write(32'h7FFF_FFFE);
        check("R10 rdata", reg_rdata_o, 32'h00FF_0100);
        do_reset();

        // R2 sweep of end-of-count, plus R4/R5 per point
        for (int e = 0; e < 4; e++) begin
            reg_write({8'h00, e[7:0], 16'h0000});
            @(negedge clk);
            osc_en_i = 1'b1;
            wait_avail(n);
            check("R2 latency", n, e * 512 + 2);
            check("R4 pending set", reg_rdata_o[0], 1);
            check("R5 irq masked", irq_o, 0);
            reg_write({8'h00, e[7:0], 16'h0100});
            check("R5 irq unmasked", irq_o, 1);
            reg_write({8'h00, e[7:0], 16'h0100});
            check("R4 write 0 keeps", reg_rdata_o[0], 1);
            reg_write({8'h00, e[7:0], 16'h0101});
            check("R4 w1c", reg_rdata_o[0], 0);
            check("R5 irq after clear", irq_o, 0);
            // R8 immediate clear on enable drop
            osc_en_i = 1'b0;
            #1;
            check("R8 avail drop", clk_avail_o, 0);
            @(negedge clk);
            @(negedge clk);
        end

        // R8 restart from zero after mid-count drop
        reg_write(32'h0002_0000);
        osc_en_i = 1'b1;
        repeat (700) @(negedge clk);
        check("R8 not yet", clk_avail_o, 0);
        osc_en_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        osc_en_i = 1'b1;
        wait_avail(n);
        check("R8 restart latency", n, 2 * 512 + 2);

        // R9 saturation: stays available while enabled
        repeat (1500) @(negedge clk);
        check("R9 still avail", clk_avail_o, 1);
        osc_en_i = 1'b0;
        @(negedge clk);

        // R3 tick gating
        do_reset();
        reg_write(32'h0001_0000);
        osc_tick_i = 1'b0;
        osc_en_i = 1'b1;
        repeat (900) @(negedge clk);
        check("R3 frozen", clk_avail_o, 0);
        osc_tick_i = 1'b1;
        wait_avail(n);
        check("R3 latency", n, 512 + 1);
        osc_en_i = 1'b0;
        @(negedge clk);

        // R4 set wins over simultaneous clear
        do_reset();
        reg_write(32'h0000_0000);
        @(negedge clk);
        osc_en_i = 1'b1;
        reg_wr_i = 1'b1;
        reg_wdata_i = 32'h0000_0001;
        @(negedge clk);
        @(negedge clk);
        reg_wr_i = 1'b0;
        reg_wdata_i = '0;
        check("R4 set wins", reg_rdata_o[0], 1);
        osc_en_i = 1'b0;
        @(negedge clk);

        // R7 bypass with enable low, R6 stickiness
        do_reset();
        reg_write(32'h8080_0000);
        check("R7 avail en low", clk_avail_o, 1);
        check("R7 no pending", reg_rdata_o[0], 0);
        reg_write(32'h0080_0000);
        check("R6 sticky", reg_rdata_o[31], 1);
        osc_en_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 avail en high", clk_avail_o, 1);
        osc_en_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 avail en dropped", clk_avail_o, 1);
        check("R7 still no pending", reg_rdata_o[0], 0);
        do_reset();
        check("R6 reset clears", reg_rdata_o[31], 0);
        check("R6 avail after reset", clk_avail_o, 0);

        done_flag = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule